// File: doc/BRIEF.md
# Range-Matched Translation Buffer with Pinned Block Slots

This block is a small fully associative address translation buffer whose entries each cover a variable-size virtual range rather than a single page. An entry records an inclusive range `[start, last]`, a physical base, and an opaque permission byte. The byte is stored and returned on a hit but is never interpreted here. The low `BLOCKS` slots are pinned block entries. Software fills and clears them by slot index, and ordinary purges leave them alone. The remaining slots are ordinary entries that the block fills itself. It takes a free slot first, and when none is free it takes a round-robin victim that never lands on a pinned slot.

Commands enter through a valid/ready port and are accepted one per cycle. `cmd_ready` is low only during reset and for the first cycle after it, so the command port never applies back-pressure in normal operation. Every accepted command produces a one-cycle `rsp_valid` pulse on the next cycle, together with an invalid-argument flag. The response has no ready input and cannot be stalled.

Lookup is a separate combinational port. All entries are compared in parallel and the result appears in the same cycle.

Top module: `range_tlb`

## Requirements
- R1: The reset condition is as follows.
  - All entries are invalid.
  - The victim pointer is `BLOCKS`.
  - Every ordinary slot is free.
  - `cmd_ready` is low while `rst_n` is low and rises on the first clock edge after release.
  - `rsp_valid` and `rsp_badarg` are low during reset.
- R2: Insert (opcode 0) with size code `s` covers 4^s pages of 2^`PG_BITS` bytes.
  - The start is `cmd_vaddr` aligned down to that size, and last = start + size - 1.
  - The physical base is `{cmd_ppn, zeros}` aligned down to the same size, keeping `PA_W` bits.
  - Any size larger than the address space covers the whole space.
- R3: A lookup hit returns the following.
  - `lk_paddr` = base + (`lk_vaddr` - start), truncated to `PA_W` bits.
  - The entry's permission byte on `lk_perm`.
  - `lk_block` high when the entry is a pinned slot.
  - If several valid entries match, the lowest slot index wins.
- R4: On a miss, `lk_imiss` rises if `lk_inst` is 1, and otherwise `lk_dmiss` rises. Exactly one of `lk_hit`, `lk_imiss`, `lk_dmiss` is high at any time. On a miss `lk_paddr`, `lk_perm` and `lk_block` are zero.
- R5: Before an insert is written, every valid ordinary entry overlapping the new range is invalidated and freed. Overlapping pinned entries stay valid.
- R6: An insert takes the lowest-indexed free ordinary slot. If none is free, it computes a victim slot and then sets the pointer to victim + 1.
  - The victim slot is the pointer's value.
  - When the pointer is below `BLOCKS` or at or above `ENTRIES`, the victim slot is `BLOCKS` instead.
- R7: Range purge (opcode 1) invalidates and frees the valid ordinary entries overlapping a given range. Pinned entries are kept. The range is defined as follows.
  - It starts at `cmd_vaddr` with the page-offset bits cleared.
  - It spans 4^c pages, where c = `cmd_vaddr[3:0]`, so a code of 0 means one page.
  - It is clamped at the top of the address space.
- R8: Purge-all (opcode 2) makes every ordinary slot invalid and free, returns the victim pointer to `BLOCKS`, and keeps valid pinned entries.
- R9: Pinned-slot commands operate on the slot named by `cmd_slot`.
  - Block insert (opcode 3) overwrites that slot, using the range and base rules of R2 and skipping the overlap purge.
  - Block purge (opcode 4) invalidates that slot.
  - If `cmd_slot` >= `BLOCKS`, either command leaves every entry unchanged and returns `rsp_badarg`.
- R10: Commands are accepted when `cmd_valid` and `cmd_ready` are both high, one per cycle.
  - An accepted command gives `rsp_valid` on the following cycle.
  - No `rsp_valid` appears without an accepted command.
  - Opcodes 5 to 7 change nothing and return `rsp_badarg`.
  - Once high after reset, `cmd_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Opcode (0 insert, 1 range purge, 2 purge-all, 3 block insert, 4 block purge) |
| cmd_vaddr | input | VA_W | Virtual address; the low 4 bits carry the purge size code |
| cmd_size | input | 4 | Insert size code (4^code pages) |
| cmd_ppn | input | PA_W-PG_BITS | Physical page number for inserts |
| cmd_perm | input | PERM_W | Opaque permission byte for inserts |
| cmd_slot | input | $clog2(ENTRIES) | Pinned slot index for block commands |
| rsp_valid | output | 1 | One-cycle pulse after an accepted command |
| rsp_badarg | output | 1 | Invalid slot or opcode for that command |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_inst | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_imiss | output | 1 | Instruction-fetch miss |
| lk_dmiss | output | 1 | Data-access miss |
| lk_paddr | output | PA_W | Translated physical address |
| lk_perm | output | PERM_W | Permission byte of the matching entry |
| lk_block | output | 1 | Matching entry is a pinned slot |

## Verification
Lookup outputs are combinational and depend only on the entry state held after the most recent clock edge. A command therefore changes what a lookup sees starting in the cycle after acceptance, and its `rsp_valid`/`rsp_badarg` appear in that same following cycle.

The bench drives inputs at the falling edge and compares all outputs 1 ns later against a behavioural model. The model applies each command only after that cycle's comparison. The response expectation produced by a command is therefore checked one cycle later, and the lookup in the cycle of a command still sees the old state.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  typedef enum logic [2:0] {
    OP_INS       = 3'd0,
    OP_PURGE     = 3'd1,
    OP_PURGE_ALL = 3'd2,
    OP_BLK_INS   = 3'd3,
    OP_BLK_PURGE = 3'd4
  } tlb_op_e;
endpackage

// File: rtl/range_tlb_lookup.sv
module range_tlb_lookup #(
  parameter int VA_W    = 32,
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]           vld,
  input  logic [ENTRIES-1:0][VA_W-1:0] first,
  input  logic [ENTRIES-1:0][VA_W-1:0] final_a,
  input  logic [VA_W-1:0]              va,
  output logic                         hit,
  output logic [SLOT_W-1:0]            idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (first[g] <= va) && (va <= final_a[g]);
  end

  // lowest index wins
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) idx = SLOT_W'(i);
  end
endmodule

// File: rtl/range_tlb_alloc.sv
module range_tlb_alloc #(
  parameter int ENTRIES = 8,
  parameter int BLOCKS  = 2,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int VP_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] avail,
  input  logic               take,
  input  logic               restart,
  output logic [SLOT_W-1:0]  pick
);
  logic [VP_W-1:0]   vp;
  logic              found;
  logic [SLOT_W-1:0] low_free, victim;

  always_comb begin
    found    = |avail;
    low_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (avail[i]) low_free = SLOT_W'(i);
    victim = (int'(vp) < BLOCKS || int'(vp) >= ENTRIES) ? SLOT_W'(BLOCKS) : SLOT_W'(vp);
    pick   = found ? low_free : victim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) vp <= VP_W'(BLOCKS);
    else if (take && !found) vp <= VP_W'(victim) + VP_W'(1);
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int PG_BITS = 12,
  parameter int ENTRIES = 8,
  parameter int BLOCKS  = 2,
  parameter int PERM_W  = 8,
  localparam int PPN_W  = PA_W - PG_BITS,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_vaddr,
  input  logic [3:0]        cmd_size,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [PERM_W-1:0] cmd_perm,
  input  logic [SLOT_W-1:0] cmd_slot,
  output logic              rsp_valid,
  output logic              rsp_badarg,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_inst,
  output logic              lk_hit,
  output logic              lk_imiss,
  output logic              lk_dmiss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [PERM_W-1:0] lk_perm,
  output logic              lk_block
);
  localparam logic [ENTRIES-1:0] ORD_MASK = {ENTRIES{1'b1}} << BLOCKS;

  logic [ENTRIES-1:0]             ent_vld, ent_free, vld_n, free_n;
  logic [ENTRIES-1:0][VA_W-1:0]   ent_start, ent_last;
  logic [ENTRIES-1:0][PA_W-1:0]   ent_pa;
  logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;

  function automatic logic [VA_W-1:0] span_mask(input logic [3:0] code);
    logic [VA_W-1:0] m;
    for (int b = 0; b < VA_W; b++) m[b] = (b < PG_BITS + 2 * int'(code));
    return m;
  endfunction

  // insert range and base
  logic [VA_W-1:0] ins_mask, ins_start, ins_last;
  logic [PA_W-1:0] ins_pa;
  assign ins_mask  = span_mask(cmd_size);
  assign ins_start = cmd_vaddr & ~ins_mask;
  assign ins_last  = ins_start | ins_mask;
  assign ins_pa    = {cmd_ppn, {PG_BITS{1'b0}}} & ~ins_mask[PA_W-1:0];

  // purge range: page aligned start, size code in low address bits
  logic [VA_W-1:0] pur_mask, pur_start, pur_last;
  logic [VA_W:0]   pur_sum;
  assign pur_mask  = span_mask(cmd_vaddr[3:0]);
  assign pur_start = {cmd_vaddr[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  assign pur_sum   = {1'b0, pur_start} + {1'b0, pur_mask};
  assign pur_last  = pur_sum[VA_W] ? {VA_W{1'b1}} : pur_sum[VA_W-1:0];

  logic [ENTRIES-1:0] ovl_ins, ovl_pur;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      ovl_ins[i] = ORD_MASK[i] && ent_vld[i] && ent_start[i] <= ins_last && ins_start <= ent_last[i];
      ovl_pur[i] = ORD_MASK[i] && ent_vld[i] && ent_start[i] <= pur_last && pur_start <= ent_last[i];
    end
  end

  logic accept, is_ins, is_pall, is_bins, slot_ok, bad_n;
  logic [SLOT_W-1:0]  alloc_slot;
  logic [ENTRIES-1:0] pick_oh;
  assign accept  = cmd_valid && cmd_ready;
  assign is_ins  = accept && cmd_op == OP_INS;
  assign is_pall = accept && cmd_op == OP_PURGE_ALL;
  assign is_bins = accept && cmd_op == OP_BLK_INS;
  assign slot_ok = int'(cmd_slot) < BLOCKS;
  assign pick_oh = {{(ENTRIES-1){1'b0}}, 1'b1} << alloc_slot;

  range_tlb_alloc #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail   ((ent_free | ovl_ins) & ORD_MASK),
    .take    (is_ins),
    .restart (is_pall),
    .pick    (alloc_slot)
  );

  always_comb begin
    vld_n  = ent_vld;
    free_n = ent_free;
    bad_n  = 1'b0;
    if (accept) begin
      case (cmd_op)
        OP_INS: begin
          vld_n  = (ent_vld & ~ovl_ins) | pick_oh;
          free_n = (ent_free | ovl_ins) & ~pick_oh;
        end
        OP_PURGE: begin
          vld_n  = ent_vld & ~ovl_pur;
          free_n = ent_free | ovl_pur;
        end
        OP_PURGE_ALL: begin
          vld_n  = ent_vld & ~ORD_MASK;
          free_n = ORD_MASK;
        end
        OP_BLK_INS:   if (slot_ok) vld_n[cmd_slot] = 1'b1; else bad_n = 1'b1;
        OP_BLK_PURGE: if (slot_ok) vld_n[cmd_slot] = 1'b0; else bad_n = 1'b1;
        default:      bad_n = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld    <= '0;
      ent_free   <= ORD_MASK;
      cmd_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_badarg <= 1'b0;
    end else begin
      ent_vld    <= vld_n;
      ent_free   <= free_n;
      cmd_ready  <= 1'b1;
      rsp_valid  <= accept;
      rsp_badarg <= bad_n;
    end
  end

  // entry payload, no reset needed (guarded by valid bits)
  always_ff @(posedge clk) begin
    if (is_ins) begin
      ent_start[alloc_slot] <= ins_start;
      ent_last[alloc_slot]  <= ins_last;
      ent_pa[alloc_slot]    <= ins_pa;
      ent_perm[alloc_slot]  <= cmd_perm;
    end else if (is_bins && slot_ok) begin
      ent_start[cmd_slot] <= ins_start;
      ent_last[cmd_slot]  <= ins_last;
      ent_pa[cmd_slot]    <= ins_pa;
      ent_perm[cmd_slot]  <= cmd_perm;
    end
  end

  logic [SLOT_W-1:0] hit_idx;
  range_tlb_lookup #(.VA_W(VA_W), .ENTRIES(ENTRIES)) u_lookup (
    .vld     (ent_vld),
    .first   (ent_start),
    .final_a (ent_last),
    .va      (lk_vaddr),
    .hit     (lk_hit),
    .idx     (hit_idx)
  );

  assign lk_imiss = !lk_hit && lk_inst;
  assign lk_dmiss = !lk_hit && !lk_inst;
  assign lk_paddr = lk_hit ? ent_pa[hit_idx] + PA_W'(lk_vaddr - ent_start[hit_idx]) : '0;
  assign lk_perm  = lk_hit ? ent_perm[hit_idx] : '0;
  assign lk_block = lk_hit && int'(hit_idx) < BLOCKS;
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int SLOT_W = 3,
  parameter int BLOCKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              rsp_valid,
  input logic              rsp_badarg,
  input logic              lk_inst,
  input logic              lk_hit,
  input logic              lk_imiss,
  input logic              lk_dmiss
);
  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);
  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready);
  // R4
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lk_hit, lk_imiss, lk_dmiss}) == 1);
  // R4
  miss_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_imiss |-> lk_inst) and (lk_dmiss |-> !lk_inst));
  // R9
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == 3'd3 || cmd_op == 3'd4) && int'(cmd_slot) >= BLOCKS)
    |=> rsp_badarg);
  // R9
  good_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == 3'd3 || cmd_op == 3'd4) && int'(cmd_slot) < BLOCKS)
    |=> !rsp_badarg);
  // R10
  badarg_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_badarg |-> rsp_valid);
endmodule

bind range_tlb range_tlb_chk #(.SLOT_W(SLOT_W), .BLOCKS(BLOCKS)) u_chk (.*);

// File: tb/test_range_tlb.sv
module test_range_tlb;
  localparam int VA_W = 32, PA_W = 28, PG = 12, N = 8, B = 2, PW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, rsp_valid, rsp_badarg;
  logic [2:0] cmd_op, cmd_slot;
  logic [31:0] cmd_vaddr, lk_vaddr;
  logic [3:0] cmd_size;
  logic [15:0] cmd_ppn;
  logic [7:0] cmd_perm, lk_perm;
  logic lk_inst, lk_hit, lk_imiss, lk_dmiss, lk_block;
  logic [27:0] lk_paddr;

  range_tlb i_range_tlb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vaddr(cmd_vaddr), .cmd_size(cmd_size), .cmd_ppn(cmd_ppn),
    .cmd_perm(cmd_perm), .cmd_slot(cmd_slot), .rsp_valid(rsp_valid), .rsp_badarg(rsp_badarg),
    .lk_vaddr(lk_vaddr), .lk_inst(lk_inst), .lk_hit(lk_hit), .lk_imiss(lk_imiss),
    .lk_dmiss(lk_dmiss), .lk_paddr(lk_paddr), .lk_perm(lk_perm), .lk_block(lk_block)
  );

  // behavioural reference
  bit m_vld[N], m_free[N];
  logic [31:0] m_st[N], m_ls[N];
  logic [27:0] m_pa[N];
  logic [7:0] m_pm[N];
  int m_vp;
  bit e_rdy, e_rv, e_bad;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [63:0] span(input int code);
    return 64'd1 << (PG + 2 * code);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_free[i] = (i >= B); end
    m_vp = B; e_rv = 0; e_bad = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [63:0] mask64;
    logic [39:0] exp_l, act_l;
    int h;
    h = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_vld[i] && m_st[i] <= lk_vaddr && lk_vaddr <= m_ls[i]) h = i;
    if (h >= 0) begin
      mask64 = {32'd0, lk_vaddr - m_st[h]};
      exp_l = {1'b1, 1'b0, 1'b0, (h < B), m_pm[h], m_pa[h] + mask64[27:0]};
    end else exp_l = {1'b0, lk_inst, !lk_inst, 1'b0, 8'd0, 28'd0};
    act_l = {lk_hit, lk_imiss, lk_dmiss, lk_block, lk_perm, lk_paddr};
    chk(act_l == exp_l, tag, "lookup{hit,im,dm,blk,perm,pa}", 64'(act_l), 64'(exp_l));
    chk({cmd_ready, rsp_valid, rsp_badarg} == {e_rdy, e_rv, e_bad}, tag,
        "{ready,rsp_valid,badarg}", 64'({cmd_ready, rsp_valid, rsp_badarg}),
        64'({e_rdy, e_rv, e_bad}));
  endtask

  task automatic model_cmd(input bit v, input logic [2:0] op, input logic [31:0] va,
                           input logic [3:0] sz, input logic [15:0] ppn,
                           input logic [7:0] pm, input logic [2:0] sl);
    logic [31:0] mk, s, l;
    logic [63:0] e;
    int slot;
    e_rv = v; e_bad = 0;
    if (!v) return;
    mk = span(int'(sz)) - 64'd1 > 64'hFFFF_FFFF ? 32'hFFFF_FFFF : 32'(span(int'(sz)) - 64'd1);
    s = va & ~mk; l = s | mk;
    case (op)
      3'd0: begin
        for (int i = B; i < N; i++)
          if (m_vld[i] && m_st[i] <= l && s <= m_ls[i]) begin m_vld[i] = 0; m_free[i] = 1; end
        slot = -1;
        for (int i = B; i < N; i++) if (m_free[i] && slot < 0) slot = i;
        if (slot < 0) begin slot = (m_vp < B || m_vp >= N) ? B : m_vp; m_vp = slot + 1; end
        m_vld[slot] = 1; m_free[slot] = 0; m_st[slot] = s; m_ls[slot] = l;
        m_pa[slot] = {ppn, 12'h000} & ~mk[27:0]; m_pm[slot] = pm;
      end
      3'd1: begin
        s = {va[31:12], 12'h000};
        e = {32'd0, s} + span(int'(va[3:0])) - 64'd1;
        l = (e > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : e[31:0];
        for (int i = B; i < N; i++)
          if (m_vld[i] && m_st[i] <= l && s <= m_ls[i]) begin m_vld[i] = 0; m_free[i] = 1; end
      end
      3'd2: begin
        for (int i = B; i < N; i++) begin m_vld[i] = 0; m_free[i] = 1; end
        m_vp = B;
      end
      3'd3: if (sl < B) begin
        m_vld[sl] = 1; m_st[sl] = s; m_ls[sl] = l;
        m_pa[sl] = {ppn, 12'h000} & ~mk[27:0]; m_pm[sl] = pm;
      end else e_bad = 1;
      3'd4: if (sl < B) m_vld[sl] = 0; else e_bad = 1;
      default: e_bad = 1;
    endcase
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [31:0] va,
                      input logic [3:0] sz, input logic [15:0] ppn, input logic [7:0] pm,
                      input logic [2:0] sl, input logic [31:0] lva, input bit li,
                      input string tag);
    cmd_valid = v; cmd_op = op; cmd_vaddr = va; cmd_size = sz; cmd_ppn = ppn;
    cmd_perm = pm; cmd_slot = sl; lk_vaddr = lva; lk_inst = li;
    #1;
    compare(tag);
    model_cmd(v, op, va, sz, ppn, pm, sl);
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] lva, input bit li, input string tag);
    step(0, 3'd0, 32'd0, 4'd0, 16'd0, 8'd0, 3'd0, lva, li, tag);
  endtask
  task automatic ins(input logic [31:0] va, input logic [3:0] sz, input logic [15:0] ppn,
                     input logic [7:0] pm, input string tag);
    step(1, 3'd0, va, sz, ppn, pm, 3'd0, va, 0, tag);
  endtask
  task automatic op_cmd(input logic [2:0] op, input logic [31:0] va, input logic [2:0] sl,
                        input string tag);
    step(1, op, va, 4'd0, 16'h5555, 8'h80, sl, va, 1, tag);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_vaddr = 0; cmd_size = 0; cmd_ppn = 0;
    cmd_perm = 0; cmd_slot = 0; lk_vaddr = 32'h0001_2345; lk_inst = 1;
    model_reset(); e_rdy = 0;
    repeat (3) @(negedge clk);
    #1 compare("R1");
    rst_n = 1;
    @(negedge clk);
    e_rdy = 1;
    look(32'h0001_2345, 1, "R1");
    look(32'h0001_2345, 0, "R4");
    ins(32'h0001_2345, 4'd0, 16'hABCD, 8'h11, "R2");
    look(32'h0001_2FFF, 0, "R3");
    look(32'h0001_3000, 1, "R4");
    ins(32'h0034_5678, 4'd2, 16'h1237, 8'h22, "R2");
    look(32'h0034_ABCD, 0, "R2");
    look(32'h0034_FFFF, 0, "R2");
    look(32'h0035_0000, 0, "R2");
    look(32'h0033_FFFF, 1, "R2");
    op_cmd(3'd3, 32'h0001_2000, 3'd0, "R9");       // block over ordinary
    look(32'h0001_2010, 0, "R3");                 // lowest index (block) wins
    op_cmd(3'd3, 32'h0077_0000, 3'd5, "R9");       // bad slot
    look(32'h0077_0000, 0, "R9");
    op_cmd(3'd4, 32'h0000_0000, 3'd2, "R9");       // bad slot purge
    look(32'h0001_2010, 0, "R9");
    op_cmd(3'd1, 32'h0001_2000, 3'd0, "R7");       // range purge keeps block
    look(32'h0001_2010, 0, "R7");
    op_cmd(3'd4, 32'h0000_0000, 3'd0, "R9");
    look(32'h0001_2010, 0, "R9");
    ins(32'h0034_4000, 4'd0, 16'h0AAA, 8'h33, "R5");  // purges the 16-page entry
    look(32'h0034_0000, 0, "R5");
    look(32'h0034_4123, 1, "R5");
    for (int k = 0; k < 11; k++)
      ins(32'h0100_0000 + (k << 20), 4'd0, 16'h0100 + 16'(k), 8'(k), "R6");
    for (int k = 0; k < 11; k++) look(32'h0100_0010 + (k << 20), 0, "R6");
    look(32'h0034_4000, 0, "R6");
    op_cmd(3'd1, 32'h0140_0001, 3'd0, "R7");       // 4-page purge
    look(32'h0140_0000, 0, "R7");
    look(32'h0150_0000, 0, "R7");
    op_cmd(3'd3, 32'h0200_0000, 3'd1, "R8");
    ins(32'h0300_0000, 4'd1, 16'h0300, 8'h44, "R8");
    op_cmd(3'd2, 32'h0000_0000, 3'd0, "R8");
    look(32'h0200_0abc, 0, "R8");
    look(32'h0300_0000, 1, "R8");
    for (int k = 0; k < 8; k++)
      ins(32'h0500_0000 + (k << 16), 4'd0, 16'h0500 + 16'(k), 8'h50, "R8");
    for (int k = 0; k < 8; k++) look(32'h0500_0000 + (k << 16), 0, "R6");
    op_cmd(3'd7, 32'h0500_0000, 3'd0, "R10");
    op_cmd(3'd5, 32'h0500_0000, 3'd0, "R10");
    look(32'h0507_0000, 0, "R10");
    op_cmd(3'd1, 32'h0000_000F, 3'd0, "R7");       // huge purge, clamped
    look(32'h0507_0000, 0, "R7");
    look(32'h0200_0000, 0, "R7");
    ins(32'h1234_5678, 4'd15, 16'hFFFF, 8'h99, "R2");
    look(32'hDEAD_BEEF, 0, "R2");
    look(32'h0200_0100, 0, "R3");
    look(32'h0000_0000, 1, "R2");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule